// File: doc/BRIEF.md
# Mixed-Trigger Vectored Interrupt Controller

This block gathers eight hardware interrupt conditions into one maskable request for a small processor and supplies the vector number when the processor acknowledges the request. Each source has a fixed trigger type. Sources 0, 2 and 3 are level sources: they request for as long as their condition is present. Sources 1, 4, 5, 6 and 7 are edge sources: a rising condition sets a pending latch, and the latch holds until software clears it.

Software reaches the block over an 8-bit I/O port bus. It sets a vector base, a per-source enable mask and a low-battery NMI enable. It reads back which sources are requesting, and it writes ones to the acknowledge port to clear latched edge requests. During the interrupt-acknowledge handshake the block presents the base plus the index of the highest-numbered requesting source. A separate non-maskable output pulses when the low-battery input rises while that feature is enabled.

Top module: `mixirq_ctrl`

## Requirements
- R1: A level source (0, 2, 3) shows in status exactly while its condition input is 1 and its enable bit is 1. A 1 written to its acknowledge bit leaves its status unchanged.
- R2: An edge source (1, 4, 5, 6, 7) whose enable bit is 1 sets its pending latch on the clock edge where its condition goes from 0 to 1. The latch stays set after the condition falls.
- R3: A rising condition on an edge source whose enable bit is 0 is not latched, and enabling the source later shows nothing. Status shows a latched bit only while its enable bit is 1. A latched bit survives a disable and shows again when re-enabled.
- R4: Writing port 0xB6 clears each edge latch whose data bit is 1. Data bits that are 0 leave their latches unchanged.
- R5: When an acknowledge of an edge source and a new rising condition on it fall on the same clock edge, the latch stays set.
- R6: Port 0xB0 holds the vector base in data bits 7:3. Bits 2:0 read as 0, and what is written to them has no effect.
- R7: Port 0xB2 is the enable mask, one bit per source with bit i for source i. It reads back as written.
- R8: Reading port 0xB4 returns status, with bit i set when source i requests. The maskable request output is 1 exactly while any status bit is 1.
- R9: While the acknowledge input is 1 and a request is present, the vector output equals the base plus the index of the highest-numbered requesting source. Otherwise it is 0.
- R10: Port 0xB7 keeps only data bit 4, the low-battery NMI enable. Other bits read as 0. The NMI output is 1 for one cycle on a low-battery rise while that bit is 1, and never while it is 0.
- R11: After reset, all registers and latches are 0, the request and NMI outputs are 0, and the vector output is 0.
- R12: Reads of any port address other than 0xB0, 0xB2, 0xB4 and 0xB7 return 0, and data out is 0 while no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | Port address |
| io_wr | input | 1 | Write strobe, sampled on the clock edge |
| io_rd | input | 1 | Read strobe, data returned combinationally |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| src_cond | input | 8 | Interrupt conditions, bit i for source i |
| lowbat | input | 1 | Low-battery detect |
| inta | input | 1 | Processor interrupt acknowledge |
| irq_req | output | 1 | Maskable interrupt request |
| vec_out | output | 8 | Vector number during acknowledge |
| nmi_out | output | 1 | Non-maskable request pulse |

## Verification
The hardest case to reach is an acknowledge write and a fresh rising edge on the same source landing on one clock edge. The latch must first be set and the condition lowered. Then, in one cycle, the bench drives the acknowledge write and raises the condition again, and reads status after that edge. A related case needs a latched edge that outlives a disable. The bench latches the edge, clears the enable, confirms status is clear, then re-enables and expects the bit to return.

// File: rtl/mixirq_pkg.sv
package mixirq_pkg;
  localparam int SRC_N  = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(SRC_N);
  localparam int BASE_W = DATA_W - IDX_W;
  localparam logic [SRC_N-1:0] LEVEL_MASK = 8'b0000_1101;
  localparam logic [SRC_N-1:0] EDGE_MASK  = ~LEVEL_MASK;
  localparam int NMI_BIT = 4;

  // highest-numbered set bit wins
  function automatic logic [IDX_W-1:0] top_index(input logic [SRC_N-1:0] p);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (p[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [DATA_W-1:0] vector_of(input logic [BASE_W-1:0] b,
                                                  input logic [IDX_W-1:0] i);
    return {b, {IDX_W{1'b0}}} + DATA_W'(i);
  endfunction
endpackage

// File: rtl/mixirq_regs.sv
module mixirq_regs
  import mixirq_pkg::*;
#(
  parameter logic [7:0] A_VBASE = 8'hB0,
  parameter logic [7:0] A_EN    = 8'hB2,
  parameter logic [7:0] A_ACK   = 8'hB6,
  parameter logic [7:0] A_NMI   = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [BASE_W-1:0] vbase,
  output logic [SRC_N-1:0]  en,
  output logic              nmi_en,
  output logic              ack_hit,
  output logic [SRC_N-1:0]  ack_bits
);
  assign ack_hit  = io_wr && (io_addr == A_ACK);
  assign ack_bits = io_wdata[SRC_N-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbase  <= '0;
      en     <= '0;
      nmi_en <= 1'b0;
    end else if (io_wr) begin
      if (io_addr == A_VBASE) vbase  <= io_wdata[DATA_W-1:IDX_W];
      if (io_addr == A_EN)    en     <= io_wdata[SRC_N-1:0];
      if (io_addr == A_NMI)   nmi_en <= io_wdata[NMI_BIT];
    end
  end
endmodule

// File: rtl/mixirq_pend.sv
module mixirq_pend
  import mixirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_cond,
  input  logic [SRC_N-1:0] en,
  input  logic             ack_hit,
  input  logic [SRC_N-1:0] ack_bits,
  output logic [SRC_N-1:0] rise_en,
  output logic [SRC_N-1:0] edge_latch,
  output logic [SRC_N-1:0] status
);
  logic [SRC_N-1:0] cond_q;
  logic [SRC_N-1:0] clr;

  assign rise_en = src_cond & ~cond_q & en & EDGE_MASK;
  assign clr     = ack_hit ? ack_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q     <= '0;
      edge_latch <= '0;
    end else begin
      cond_q     <= src_cond;
      // a new edge overrides a clear in the same cycle
      edge_latch <= ((edge_latch & ~clr) | rise_en) & EDGE_MASK;
    end
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    if (LEVEL_MASK[g]) begin : g_level
      assign status[g] = src_cond[g] & en[g];
    end else begin : g_edge
      assign status[g] = edge_latch[g] & en[g];
    end
  end
endmodule

// File: rtl/mixirq_nmi.sv
module mixirq_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic lowbat,
  input  logic nmi_en,
  output logic nmi_out
);
  logic lowbat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lowbat_q <= 1'b0;
    else        lowbat_q <= lowbat;
  end

  assign nmi_out = nmi_en & lowbat & ~lowbat_q;
endmodule

// File: rtl/mixirq_ctrl.sv
module mixirq_ctrl
  import mixirq_pkg::*;
#(
  parameter logic [7:0] A_VBASE = 8'hB0,
  parameter logic [7:0] A_EN    = 8'hB2,
  parameter logic [7:0] A_STAT  = 8'hB4,
  parameter logic [7:0] A_ACK   = 8'hB6,
  parameter logic [7:0] A_NMI   = 8'hB7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic [7:0] src_cond,
  input  logic       lowbat,
  input  logic       inta,
  output logic       irq_req,
  output logic [7:0] vec_out,
  output logic       nmi_out
);
  logic [BASE_W-1:0] vbase;
  logic [SRC_N-1:0]  en;
  logic              nmi_en;
  logic              ack_hit;
  logic [SRC_N-1:0]  ack_bits;
  logic [SRC_N-1:0]  rise_en;
  logic [SRC_N-1:0]  edge_latch;
  logic [SRC_N-1:0]  status;

  mixirq_regs #(
    .A_VBASE(A_VBASE), .A_EN(A_EN), .A_ACK(A_ACK), .A_NMI(A_NMI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .vbase(vbase), .en(en), .nmi_en(nmi_en),
    .ack_hit(ack_hit), .ack_bits(ack_bits)
  );

  mixirq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .en(en),
    .ack_hit(ack_hit), .ack_bits(ack_bits), .rise_en(rise_en),
    .edge_latch(edge_latch), .status(status)
  );

  mixirq_nmi u_nmi (
    .clk(clk), .rst_n(rst_n), .lowbat(lowbat), .nmi_en(nmi_en),
    .nmi_out(nmi_out)
  );

  assign irq_req = |status;
  assign vec_out = (inta && irq_req) ? vector_of(vbase, top_index(status)) : '0;

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      case (io_addr)
        A_VBASE: io_rdata = {vbase, {IDX_W{1'b0}}};
        A_EN:    io_rdata = en;
        A_STAT:  io_rdata = status;
        A_NMI:   io_rdata = 8'(nmi_en) << NMI_BIT;
        default: io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mixirq_chk.sv
module mixirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       inta,
  input logic [7:0] vec_out,
  input logic       nmi_out,
  input logic       nmi_en,
  input logic       ack_hit,
  input logic [7:0] rise_en,
  input logic [7:0] edge_latch
);
  a_r5_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_en != 0) |=> ((edge_latch & $past(rise_en)) == $past(rise_en)));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> ((edge_latch & $past(io_wdata) & ~$past(rise_en)) == 0));

  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_hit |=> ((edge_latch & $past(edge_latch)) == $past(edge_latch)));

  a_r10_nmi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |=> !nmi_out);

  a_r10_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> nmi_en);

  a_r9_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |-> (vec_out == 8'h00));

  a_r6_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 8'hB0) |-> (io_rdata[2:0] == 3'b000));
endmodule

bind mixirq_ctrl mixirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .inta(inta), .vec_out(vec_out),
  .nmi_out(nmi_out), .nmi_en(nmi_en), .ack_hit(ack_hit),
  .rise_en(rise_en), .edge_latch(edge_latch)
);

// File: tb/mixirq_ctrl_test.sv
module mixirq_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [7:0] src_cond = '0;
  logic       lowbat = 1'b0;
  logic       inta = 1'b0;
  logic       irq_req;
  logic [7:0] vec_out;
  logic       nmi_out;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  mixirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .src_cond(src_cond),
    .lowbat(lowbat), .inta(inta), .irq_req(irq_req), .vec_out(vec_out),
    .nmi_out(nmi_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  // advance one clock; return 1 time unit after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic check_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    check_reg("R11 vbase", 8'hB0, 8'h00);
    check_reg("R11 enable", 8'hB2, 8'h00);
    check_reg("R11 status", 8'hB4, 8'h00);
    check_reg("R11 nmi ctl", 8'hB7, 8'h00);
    check("R11 irq_req", {7'b0, irq_req}, 8'h00);
    check("R11 nmi_out", {7'b0, nmi_out}, 8'h00);
    check("R11 vec_out", vec_out, 8'h00);
  endtask

  task automatic t_regs();
    wr(8'hB0, 8'hFF);
    check_reg("R6 base low bits", 8'hB0, 8'hF8);
    wr(8'hB2, 8'hA5);
    check_reg("R7 enable readback", 8'hB2, 8'hA5);
    wr(8'hB7, 8'hFF);
    check_reg("R10 nmi ctl bit4 only", 8'hB7, 8'h10);
    wr(8'hB7, 8'h00);
    check_reg("R12 unmapped read", 8'h33, 8'h00);
    io_addr = 8'hB2; #1;
    check("R12 no read strobe", io_rdata, 8'h00);
    wr(8'hB0, 8'h00);
  endtask

  task automatic t_level();
    wr(8'hB2, 8'hFF);
    src_cond = 8'h04; #1;
    check_reg("R1 level shows", 8'hB4, 8'h04);
    check("R8 irq with level", {7'b0, irq_req}, 8'h01);
    wr(8'hB6, 8'h0D);
    check_reg("R1 ack ignored on level", 8'hB4, 8'h04);
    wr(8'hB2, 8'hFB);
    check_reg("R1 level disabled", 8'hB4, 8'h00);
    check("R8 irq off when masked", {7'b0, irq_req}, 8'h00);
    wr(8'hB2, 8'hFF);
    src_cond = 8'h00; #1;
    check_reg("R1 level removed", 8'hB4, 8'h00);
  endtask

  task automatic t_edge();
    src_cond = 8'h20; tick();
    src_cond = 8'h00; tick();
    check_reg("R2 edge latched", 8'hB4, 8'h20);
    check("R8 irq with edge", {7'b0, irq_req}, 8'h01);
    wr(8'hB6, 8'hDF);
    check_reg("R4 zero bit no effect", 8'hB4, 8'h20);
    wr(8'hB6, 8'h20);
    check_reg("R4 ack clears", 8'hB4, 8'h00);
  endtask

  task automatic t_masked();
    wr(8'hB2, 8'hEF);
    src_cond = 8'h10; tick();
    src_cond = 8'h00; tick();
    check_reg("R3 masked edge status", 8'hB4, 8'h00);
    wr(8'hB2, 8'hFF);
    check_reg("R3 masked edge not latched", 8'hB4, 8'h00);
    src_cond = 8'h40; tick();
    src_cond = 8'h00; tick();
    wr(8'hB2, 8'hBF);
    check_reg("R3 latched but disabled", 8'hB4, 8'h00);
    wr(8'hB2, 8'hFF);
    check_reg("R3 latch survives disable", 8'hB4, 8'h40);
    wr(8'hB6, 8'h40);
  endtask

  task automatic t_collide();
    src_cond = 8'h80; tick();
    src_cond = 8'h00; tick();
    // new rise and acknowledge on the same edge
    src_cond = 8'h80;
    wr(8'hB6, 8'h80);
    check_reg("R5 edge wins over ack", 8'hB4, 8'h80);
    src_cond = 8'h00;
    wr(8'hB6, 8'h80);
    check_reg("R5 later ack clears", 8'hB4, 8'h00);
  endtask

  task automatic t_vector();
    wr(8'hB0, 8'h47);
    src_cond = 8'h24; tick();
    src_cond = 8'h04; tick();
    inta = 1'b1; #1;
    check("R9 highest source 5", vec_out, 8'h45);
    wr(8'hB6, 8'h20);
    check("R9 next source 2", vec_out, 8'h42);
    inta = 1'b0; #1;
    check("R9 idle without inta", vec_out, 8'h00);
    src_cond = 8'h00; inta = 1'b1; #1;
    check("R9 nothing pending", vec_out, 8'h00);
    inta = 1'b0;
  endtask

  task automatic t_nmi();
    logic seen;
    seen = 1'b0;
    lowbat = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 if (nmi_out) seen = 1'b1;
      tick();
    end
    check("R10 no nmi when disabled", {7'b0, seen}, 8'h00);
    lowbat = 1'b0; tick();
    wr(8'hB7, 8'h10);
    lowbat = 1'b1; #1;
    check("R10 nmi on rise", {7'b0, nmi_out}, 8'h01);
    tick();
    check("R10 nmi one cycle", {7'b0, nmi_out}, 8'h00);
    lowbat = 1'b0; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_masked();
    t_collide();
    t_vector();
    t_nmi();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule